// File: doc/BRIEF.md
# Interrupt Distributor Control and Type Registers

This block holds the global control word of an interrupt distributor and serves its read-only type word. It decodes a word-addressed register bus with byte strobes and a per-access security attribute. The control word carries three group enables, a single-security-state flag and two routing-enable bits. It presents a full view to secure accesses and a reduced view to non-secure ones, and the set of writable bits depends on both the access type and the security mode.

Once the single-security-state flag is set, it stays set until reset. Setting it drops the secure group-1 enable and the non-secure routing-enable bit at the same time. From then on, secure and non-secure accesses share one view. The type word reports the fixed capability fields, the interrupt-line count and whether two security states are in force. Every other offset reads as zero and ignores writes, and the status word is one of them.

The outputs drive the rest of the distributor directly. They are the three group enables and the single-security-state flag.

Top module: `irq_dist_ctl`

## Requirements
- R1: After reset, all three group enables and the single-security-state flag (control bit 6) are 0. A secure control read returns 0x0000_0030: bit 4 and bit 5 are set and every other bit is 0. A non-secure control read returns 0x0000_0010.
- R2: Control bit 4 always reads 1. Control bit 5 reads 1 whenever bit 6 is 0. Writes to either bit have no effect, and bit 31 always reads 0.
- R3: With bit 6 clear, a secure write to the control word (offset 0x000) updates bit 0 (group-0 enable), bit 1 (non-secure group-1 enable), bit 2 (secure group-1 enable) and bit 6. These bits drive the outputs `grp0_en`, `grp1ns_en`, `grp1s_en` and `sec_disabled`.
- R4: With bit 6 clear, a non-secure write changes only bit 1. Bits 0, 2 and 6 keep their values.
- R5: With bit 6 clear, a non-secure control read returns the secure value ANDed with 0x8000_0012.
- R6: A write that sets bit 6 also clears bit 2 and bit 5 in the same cycle. Bit 6 then stays 1 until reset, and bit 2 stays 0 until reset.
- R7: With bit 6 set, any write of either security type can change only bits 0 and 1, and both kinds of read return the full control value.
- R8: The type word (offset 0x004) reads bits 25 and 24 as 1, 0xF in bits [23:19], NOT bit 6 of the control word in bit 10, and NUM_IRQ/32-1 in bits [4:0]. All other bits are 0. With the default NUM_IRQ of 96, it reads 0x0378_0402 with bit 6 clear and 0x0378_0002 with bit 6 set.
- R9: Writes to the type word, to the status word (offset 0x010) and to unassigned offsets change nothing. Reads of the status word and of unassigned offsets return 0.
- R10: The control bits lie in byte lane 0, and a control write takes effect only when strobe bit 0 is set.
- R11: Read data is registered. It appears in the cycle after `bus_rd` is sampled and holds its value while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte-lane strobes for writes |
| bus_secure | input | 1 | 1 for a secure access, 0 for non-secure |
| bus_rdata | output | 32 | Registered read data |
| grp0_en | output | 1 | Group-0 enable |
| grp1ns_en | output | 1 | Non-secure group-1 enable |
| grp1s_en | output | 1 | Secure group-1 enable |
| sec_disabled | output | 1 | Single-security-state flag |

## Verification
The hardest condition to reach from the ports is the single-security-state mode, because it cannot be left once it is entered and only a secure write can enter it. The bench first runs every two-state scenario: secure and non-secure writes, reduced reads, strobe gating and read-only offsets. It then issues a secure write that sets the flag together with the secure group-1 enable, to show that the clear takes priority. It goes on with writes of both security types in that mode, then applies a second reset to confirm that only reset leaves the mode.

// File: rtl/irq_dist_ctl.sv
module irq_dist_ctl #(
  parameter int NUM_IRQ = 96,
  parameter int ADDR_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_wstrb,
  input  logic              bus_secure,
  output logic [31:0]       bus_rdata,
  output logic              grp0_en,
  output logic              grp1ns_en,
  output logic              grp1s_en,
  output logic              sec_disabled
);

  localparam int WA = ADDR_W - 2;
  localparam logic [WA-1:0] W_CTRL = WA'(0);
  localparam logic [WA-1:0] W_TYPE = WA'(1);
  localparam logic [4:0]    LINES  = 5'(NUM_IRQ / 32 - 1);
  localparam logic [31:0]   NS_RD_MASK = 32'h8000_0012;

  logic en0_q, en1ns_q, en1s_q, ds_q, rt_ns_q;
  logic [31:0] rdata_q;

  wire [WA-1:0] widx     = bus_addr[ADDR_W-1:2];
  wire          ctrl_hit = (widx == W_CTRL);
  wire          type_hit = (widx == W_TYPE);
  wire          ns_view  = !bus_secure && !ds_q;

  wire [31:0] ctrl_full = {25'b0, ds_q, rt_ns_q, 1'b1, 1'b0, en1s_q, en1ns_q, en0_q};
  wire [31:0] type_val  = {6'b0, 1'b1, 1'b1, 5'hF, 8'b0, ~ds_q, 5'b0, LINES};

  wire [31:0] lane_m = {{8{bus_wstrb[3]}}, {8{bus_wstrb[2]}},
                        {8{bus_wstrb[1]}}, {8{bus_wstrb[0]}}};
  wire [31:0] mode_m = ds_q ? 32'h0000_0003 :
                       bus_secure ? 32'h0000_0047 : 32'h0000_0002;
  wire        wr_ctrl = bus_wr && ctrl_hit;
  wire [31:0] wm      = wr_ctrl ? (mode_m & lane_m) : 32'h0;
  wire        ds_set  = wm[6] && bus_wdata[6];

  wire unused_wd = ^{bus_wdata[31:7], bus_wdata[5:3], bus_addr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en0_q   <= 1'b0;
      en1ns_q <= 1'b0;
      en1s_q  <= 1'b0;
      ds_q    <= 1'b0;
      rt_ns_q <= 1'b1;
    end else begin
      if (wm[0]) en0_q   <= bus_wdata[0];
      if (wm[1]) en1ns_q <= bus_wdata[1];
      if (ds_set)     en1s_q <= 1'b0;
      else if (wm[2]) en1s_q <= bus_wdata[2];
      if (ds_set) begin
        ds_q    <= 1'b1;
        rt_ns_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rdata_q <= 32'h0;
    else if (bus_rd) begin
      if (ctrl_hit)      rdata_q <= ns_view ? (ctrl_full & NS_RD_MASK) : ctrl_full;
      else if (type_hit) rdata_q <= type_val;
      else               rdata_q <= 32'h0;
    end
  end

  assign bus_rdata    = rdata_q;
  assign grp0_en      = en0_q;
  assign grp1ns_en    = en1ns_q;
  assign grp1s_en     = en1s_q;
  assign sec_disabled = ds_q;

  AST_DS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ds_q |=> ds_q) else $error("ds cleared without reset"); // R6

  AST_G1S_OFF_IN_DS: assert property (@(posedge clk) disable iff (!rst_n)
    ds_q |-> !grp1s_en) else $error("secure group-1 enable set in single-state mode"); // R6

  AST_RT_NS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ds_q |-> rt_ns_q) else $error("routing bit lost while two states active"); // R2

  AST_NS_WRITE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && ctrl_hit && !bus_secure && !ds_q) |=>
      ($stable(grp0_en) && $stable(grp1s_en) && $stable(sec_disabled)))
    else $error("non-secure write touched protected bits"); // R4

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)) else $error("read data moved without a read"); // R11

  AST_RO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !ctrl_hit) |=>
      ($stable(grp0_en) && $stable(grp1ns_en) && $stable(grp1s_en) && $stable(sec_disabled)))
    else $error("write to other offset changed control"); // R9

endmodule

// File: tb/irq_dist_ctl_tb.sv
module irq_dist_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic [31:0] bus_rdata;
  logic grp0_en, grp1ns_en, grp1s_en, sec_disabled;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  irq_dist_ctl #(.NUM_IRQ(96), .ADDR_W(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_secure(bus_secure), .bus_rdata(bus_rdata), .grp0_en(grp0_en),
    .grp1ns_en(grp1ns_en), .grp1s_en(grp1s_en), .sec_disabled(sec_disabled));

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s, input logic sec);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s; bus_secure = sec;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic sec, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_secure = sec;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] outs();
    return {28'b0, sec_disabled, grp1s_en, grp1ns_en, grp0_en};
  endfunction

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 outputs", outs(), 32'h0);
    rd(12'h000, 1'b1, d); chk("R1 secure ctrl", d, 32'h30);
    rd(12'h000, 1'b0, d); chk("R1 ns ctrl", d, 32'h10);
    rd(12'h004, 1'b1, d); chk("R8 type two-state", d, 32'h0378_0402);
  endtask

  task automatic t_secure();
    logic [31:0] d;
    wr(12'h000, 32'h7, 4'h1, 1'b1);
    chk("R3 outputs", outs(), 32'h7);
    rd(12'h000, 1'b1, d); chk("R3 ctrl", d, 32'h37);
    rd(12'h000, 1'b0, d); chk("R5 ns view", d, 32'h12);
    wr(12'h000, 32'h0, 4'hF, 1'b1);
    rd(12'h000, 1'b1, d); chk("R2 routing bits after zero write", d, 32'h30);
    wr(12'h000, 32'hFFFF_FFBF, 4'hF, 1'b1);
    rd(12'h000, 1'b1, d); chk("R2 bit31 reads zero", d, 32'h37);
  endtask

  task automatic t_nonsecure();
    logic [31:0] d;
    wr(12'h000, 32'h0, 4'hF, 1'b0);
    chk("R4 only bit1 cleared", outs(), 32'h5);
    wr(12'h000, 32'h0000_0047, 4'hF, 1'b0);
    chk("R4 ds not writable ns", outs(), 32'h7);
    rd(12'h004, 1'b0, d); chk("R4 type still two-state", d, 32'h0378_0402);
    rd(12'h000, 1'b0, d); chk("R5 ns view after ns write", d, 32'h12);
  endtask

  task automatic t_strobe();
    logic [31:0] d;
    wr(12'h000, 32'h0, 4'hE, 1'b1);
    rd(12'h000, 1'b1, d); chk("R10 lane0 strobe off", d, 32'h37);
  endtask

  task automatic t_readonly();
    logic [31:0] d;
    wr(12'h004, 32'h0, 4'hF, 1'b1);
    rd(12'h004, 1'b1, d); chk("R9 type unchanged", d, 32'h0378_0402);
    wr(12'h010, 32'h0, 4'hF, 1'b1);
    wr(12'h080, 32'h0, 4'hF, 1'b1);
    chk("R9 control unchanged", outs(), 32'h7);
    rd(12'h010, 1'b1, d); chk("R9 status zero", d, 32'h0);
    rd(12'h080, 1'b1, d); chk("R9 unassigned zero", d, 32'h0);
  endtask

  task automatic t_hold();
    logic [31:0] d;
    rd(12'h004, 1'b1, d);
    @(negedge clk); bus_addr = 12'h000;
    repeat (3) @(negedge clk);
    chk("R11 read data held", bus_rdata, 32'h0378_0402);
    @(negedge clk); bus_rd = 1'b1; bus_secure = 1'b1;
    chk("R11 not yet updated", bus_rdata, 32'h0378_0402);
    @(negedge clk); bus_rd = 1'b0;
    chk("R11 updated next cycle", bus_rdata, 32'h37);
  endtask

  task automatic t_single_state();
    logic [31:0] d;
    wr(12'h000, 32'h47, 4'h1, 1'b1);
    chk("R6 outputs after ds set", outs(), 32'hB);
    rd(12'h000, 1'b1, d); chk("R6 ctrl after ds set", d, 32'h53);
    rd(12'h004, 1'b1, d); chk("R8 type single-state", d, 32'h0378_0002);
    wr(12'h000, 32'h0, 4'hF, 1'b1);
    rd(12'h000, 1'b1, d); chk("R6 ds sticky", d, 32'h50);
    wr(12'h000, 32'h3, 4'hF, 1'b0);
    chk("R7 ns writes bits 0,1", outs(), 32'hB);
    wr(12'h000, 32'h4, 4'hF, 1'b1);
    rd(12'h000, 1'b0, d); chk("R7 bit2 locked, full ns view", d, 32'h50);
    do_reset();
    rd(12'h000, 1'b1, d); chk("R1 reset leaves single-state", d, 32'h30);
    chk("R1 outputs after second reset", outs(), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_secure();
    t_nonsecure();
    t_strobe();
    t_readonly();
    t_hold();
    t_single_state();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule